// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block sits at the front of a local memory bus controller. Each transaction arrives with its upper address bits, a size code and a read/write flag. The block compares the address with a set of bank registers. Each bank pairs a base word with an option word. The outcome is one chip-select bank and the code of the back-end machine that will run the access, either a general chip-select engine, a NAND engine or one of three programmable engines. The decode result is registered and appears one clock after the request, together with the port width of the bank. The size and direction of the request travel alongside, aligned to that result. A request that finds no usable bank produces a one-cycle miss pulse instead of a chip-select.

Bank 0 leaves reset already set up from boot strap pins. Its mask is all zeros, so every address falls into it, and its port width and machine code are taken from the boot mode. This lets the first fetches after power-up reach a boot memory before any software has run. Software can then shrink or move the bank through the register write port.

Top module: `cs_bank_decoder`

## Requirements
- R1: There are 8 banks. A write with `reg_we` high targets bank `reg_bank`. With `reg_sel`=0 it loads the base word: base address = bits [31:15], port width = bits [12:11], machine code = bits [7:5], enable = bit 0. With `reg_sel`=1 it loads the option word: address mask = bits [31:15], large-page flag = bit 10.
- R2: A written value is used from the clock after the write. A request presented in the same cycle as a write is decoded with the values held before that write.
- R3: A bank matches when its enable bit is 1 and, for every bit position where its mask is 1, `txn_addr_hi` equals its base address. Positions where the mask is 0 are ignored.
- R4: When more than one bank matches, the bank with the lowest index is chosen.
- R5: One clock after a request with `txn_valid` high that selects a bank, the outputs are as follows:
  - `hit_valid` is 1.
  - `cs_sel` has exactly the chosen bank's bit set.
  - `mach_sel`, `port_size` and `large_page` show that bank's fields.
  - `out_size` and `out_write` repeat the request's `txn_size` and `txn_write`.
- R6: One clock after a request that matches no bank, `miss` is 1 for that cycle, and `hit_valid`, `cs_sel`, `mach_sel`, `port_size` and `large_page` are 0.
- R7: Machine codes 000 (general), 001 (NAND), 100, 101 and 110 (programmable) are legal, and the others are reserved. If the chosen bank holds a reserved code, the request is reported as a miss. A higher-index bank that also matches is not used.
- R8: The boot mode sets bank 0 at reset:
  - `boot_mode`=00: port width 01, machine 000, enabled.
  - `boot_mode`=01: port width 10, machine 000, enabled.
  - `boot_mode`=10: port width 01, machine 001, enabled, with the large-page flag equal to `boot_large_page`.
  - Outside mode 10, the large-page flag is 0.
- R9: At reset, bank 0 has base address 0 and mask 0, so it matches every address. All other banks reset to all zeros, which leaves them disabled. All outputs are 0 during and just after reset.
- R10: With `boot_mode`=11, bank 0 resets disabled, so every request misses until software enables a bank.
- R11: One clock after a cycle with `txn_valid` low, `hit_valid`, `miss` and `cs_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 2 | Boot strap code that sets bank 0 at reset |
| boot_large_page | input | 1 | Boot strap large-page flag, used in NAND boot mode |
| reg_we | input | 1 | Register write strobe |
| reg_bank | input | 3 | Bank index of the write |
| reg_sel | input | 1 | 0 = base word, 1 = option word |
| reg_wdata | input | 32 | Register write data |
| txn_valid | input | 1 | Request present this cycle |
| txn_addr_hi | input | 17 | Request address bits 31 down to 15 |
| txn_size | input | 2 | Request size code, passed through |
| txn_write | input | 1 | Request direction, 1 = write |
| hit_valid | output | 1 | A bank was selected for the previous request |
| miss | output | 1 | The previous request found no usable bank |
| cs_sel | output | 8 | One-hot chip-select of the chosen bank |
| mach_sel | output | 3 | Machine code of the chosen bank |
| port_size | output | 2 | Port width code of the chosen bank |
| large_page | output | 1 | Large-page flag of the chosen bank |
| out_size | output | 2 | Size code of the decoded request |
| out_write | output | 1 | Direction of the decoded request |

## Verification
The bench aims at the following cases:
- **Overlapping banks.** A decoder with inverted priority would assert the higher-index chip-select.
- **Reserved machine code on the winning bank.** A design that falls through to the next matching bank, or forwards the reserved code, would show a hit where a miss is expected.
- **Write and decode in the same cycle.** A write-through register path would decode against the new value one cycle too early.
- **All four boot modes.** A wrong strap table or a nonzero reset mask would give a wrong port width, a wrong machine code or a missed catch-all. The external boot mode must miss every request.
- **Mask handling.** Random traffic flips address bits under cleared mask positions, and a design that compared them would miss.

// File: rtl/csdec_pkg.sv
// Package: shared field positions, code values and helpers for the
// chip-select bank decoder. Assumes register words at least 13 bits wide.
package csdec_pkg;

    // Bit positions inside the base and option words
    localparam int VALID_BIT = 0;
    localparam int MS_LSB    = 5;
    localparam int PAGE_BIT  = 10;
    localparam int PS_LSB    = 11;

    // Back-end machine codes
    localparam logic [2:0] MS_GENERAL = 3'b000;
    localparam logic [2:0] MS_NAND    = 3'b001;
    localparam logic [2:0] MS_PROG_A  = 3'b100;
    localparam logic [2:0] MS_PROG_B  = 3'b101;
    localparam logic [2:0] MS_PROG_C  = 3'b110;

    // Port width codes
    localparam logic [1:0] PS_BYTE = 2'b01;
    localparam logic [1:0] PS_HALF = 2'b10;

    typedef enum logic [1:0] {
        BOOT_NOR8     = 2'b00,
        BOOT_NOR16    = 2'b01,
        BOOT_NAND8    = 2'b10,
        BOOT_EXTERNAL = 2'b11
    } boot_e;

    // True when a machine code names an existing back-end machine
    function automatic logic msel_legal(input logic [2:0] code);
        return (code == MS_GENERAL) || (code == MS_NAND) ||
               (code == MS_PROG_A)  || (code == MS_PROG_B) ||
               (code == MS_PROG_C);
    endfunction

endpackage

// File: rtl/csdec_bank_regs.sv
// Module: storage for one bank's decoded fields (base, width, machine,
// enable, mask, page flag). Reset values arrive as inputs so the same
// module serves the boot bank and the plain banks. Writes land on the
// clock edge; readers see them from the next cycle.
module csdec_bank_regs #(
    parameter int HI_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rst_psize,
    input  logic [2:0]      rst_msel,
    input  logic            rst_valid,
    input  logic            rst_page,
    input  logic            wr_base,
    input  logic            wr_opt,
    input  logic [HI_W-1:0] wr_hi,
    input  logic [1:0]      wr_psize,
    input  logic [2:0]      wr_msel,
    input  logic            wr_valid,
    input  logic            wr_page,
    output logic [HI_W-1:0] base_hi,
    output logic [1:0]      psize,
    output logic [2:0]      msel,
    output logic            valid,
    output logic [HI_W-1:0] mask_hi,
    output logic            page
);

    // Base word fields: reset to zero address plus strap-driven fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            psize   <= rst_psize;
            msel    <= rst_msel;
            valid   <= rst_valid;
        end else if (wr_base) begin
            base_hi <= wr_hi;
            psize   <= wr_psize;
            msel    <= wr_msel;
            valid   <= wr_valid;
        end
    end

    // Option word fields: the mask resets to zero (matches everything)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi <= '0;
            page    <= rst_page;
        end else if (wr_opt) begin
            mask_hi <= wr_hi;
            page    <= wr_page;
        end
    end

endmodule

// File: rtl/csdec_match.sv
// Module: per-bank address comparator. A bank hits when it is enabled
// and all address bits selected by its mask equal its base bits.
module csdec_match #(
    parameter int HI_W = 17
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] base_hi,
    input  logic [HI_W-1:0] mask_hi,
    input  logic            valid,
    output logic            hit
);

    // Masked equality compare gated by the enable bit
    always_comb hit = valid && (((addr_hi ^ base_hi) & mask_hi) == '0);

endmodule

// File: rtl/csdec_prio.sv
// Module: fixed-priority picker; the lowest-index set request wins.
// Assumes at least two requesters.
module csdec_prio #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest set index is the last one kept
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_bank_decoder.sv
// Module: chip-select bank decoder top. Holds NUM_BANKS register pairs,
// matches each request against all of them in one cycle and registers
// the chosen bank, its machine code and port width. Bank 0 resets from
// boot straps with a zero mask. Assumes CMP_LSB >= 13 so the address
// field sits above the control fields of the base word.
module cs_bank_decoder
    import csdec_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 32,
    parameter int CMP_LSB   = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   boot_mode,
    input  logic                         boot_large_page,
    input  logic                         reg_we,
    input  logic [$clog2(NUM_BANKS)-1:0] reg_bank,
    input  logic                         reg_sel,
    input  logic [ADDR_W-1:0]            reg_wdata,
    input  logic                         txn_valid,
    input  logic [ADDR_W-1:CMP_LSB]      txn_addr_hi,
    input  logic [1:0]                   txn_size,
    input  logic                         txn_write,
    output logic                         hit_valid,
    output logic                         miss,
    output logic [NUM_BANKS-1:0]         cs_sel,
    output logic [2:0]                   mach_sel,
    output logic [1:0]                   port_size,
    output logic                         large_page,
    output logic [1:0]                   out_size,
    output logic                         out_write
);

    localparam int HI_W  = ADDR_W - CMP_LSB;
    localparam int IDX_W = $clog2(NUM_BANKS);

    // Control bits of the write word that carry no field
    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[CMP_LSB-1:PS_LSB+2],
                            reg_wdata[PAGE_BIT-1:MS_LSB+3],
                            reg_wdata[MS_LSB-1:VALID_BIT+1]};

    // Boot-strap reset image for bank 0
    logic [1:0] boot_psize;
    logic [2:0] boot_msel;
    logic       boot_valid;
    logic       boot_page;

    // Translate the strap code into bank 0 reset fields
    always_comb begin
        boot_psize = '0;
        boot_msel  = MS_GENERAL;
        boot_valid = 1'b0;
        boot_page  = 1'b0;
        case (boot_e'(boot_mode))
            BOOT_NOR8:  begin boot_psize = PS_BYTE; boot_valid = 1'b1; end
            BOOT_NOR16: begin boot_psize = PS_HALF; boot_valid = 1'b1; end
            BOOT_NAND8: begin
                boot_psize = PS_BYTE;
                boot_msel  = MS_NAND;
                boot_valid = 1'b1;
                boot_page  = boot_large_page;
            end
            default: ;
        endcase
    end

    logic [HI_W-1:0]      b_base [NUM_BANKS];
    logic [HI_W-1:0]      b_mask [NUM_BANKS];
    logic [1:0]           b_ps   [NUM_BANKS];
    logic [2:0]           b_ms   [NUM_BANKS];
    logic [NUM_BANKS-1:0] b_val;
    logic [NUM_BANKS-1:0] b_pg;
    logic [NUM_BANKS-1:0] hits;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam bit IS_BOOT = (g == 0);
        logic sel_me;
        assign sel_me = reg_we && (reg_bank == IDX_W'(g));

        csdec_bank_regs #(.HI_W(HI_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .rst_psize (IS_BOOT ? boot_psize : 2'b00),
            .rst_msel  (IS_BOOT ? boot_msel  : 3'b000),
            .rst_valid (IS_BOOT ? boot_valid : 1'b0),
            .rst_page  (IS_BOOT ? boot_page  : 1'b0),
            .wr_base   (sel_me && !reg_sel),
            .wr_opt    (sel_me &&  reg_sel),
            .wr_hi     (reg_wdata[ADDR_W-1:CMP_LSB]),
            .wr_psize  (reg_wdata[PS_LSB+1:PS_LSB]),
            .wr_msel   (reg_wdata[MS_LSB+2:MS_LSB]),
            .wr_valid  (reg_wdata[VALID_BIT]),
            .wr_page   (reg_wdata[PAGE_BIT]),
            .base_hi   (b_base[g]),
            .psize     (b_ps[g]),
            .msel      (b_ms[g]),
            .valid     (b_val[g]),
            .mask_hi   (b_mask[g]),
            .page      (b_pg[g])
        );

        csdec_match #(.HI_W(HI_W)) u_match (
            .addr_hi (txn_addr_hi),
            .base_hi (b_base[g]),
            .mask_hi (b_mask[g]),
            .valid   (b_val[g]),
            .hit     (hits[g])
        );
    end

    logic [NUM_BANKS-1:0] win_onehot;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any;

    csdec_prio #(.N(NUM_BANKS)) u_prio (
        .req   (hits),
        .grant (win_onehot),
        .idx   (win_idx),
        .any   (win_any)
    );

    // Qualify the winner: a reserved machine code turns the hit into a miss
    logic dec_hit, dec_miss;
    always_comb begin
        dec_hit  = txn_valid && win_any && msel_legal(b_ms[win_idx]);
        dec_miss = txn_valid && !dec_hit;
    end

    // Output stage: one register level between request and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            miss       <= 1'b0;
            cs_sel     <= '0;
            mach_sel   <= '0;
            port_size  <= '0;
            large_page <= 1'b0;
            out_size   <= '0;
            out_write  <= 1'b0;
        end else begin
            hit_valid  <= dec_hit;
            miss       <= dec_miss;
            cs_sel     <= dec_hit ? win_onehot : '0;
            mach_sel   <= dec_hit ? b_ms[win_idx] : 3'b000;
            port_size  <= dec_hit ? b_ps[win_idx] : 2'b00;
            large_page <= dec_hit && b_pg[win_idx];
            out_size   <= txn_valid ? txn_size : 2'b00;
            out_write  <= txn_valid && txn_write;
        end
    end

endmodule

// File: rtl/csdec_checker.sv
// Module: property checker for the chip-select bank decoder, attached
// by bind. Observes ports only.
module csdec_checker
    import csdec_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txn_valid,
    input logic                 hit_valid,
    input logic                 miss,
    input logic [NUM_BANKS-1:0] cs_sel,
    input logic [2:0]           mach_sel
);

    // R4: at most one chip-select at any time
    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));

    // R5: a reported hit carries exactly one chip-select
    assert_hit_one_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ($countones(cs_sel) == 1));

    // R6: a miss never comes with a hit or a chip-select
    assert_miss_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!hit_valid && (cs_sel == '0)));

    // R7: a reported hit never forwards a reserved machine code
    assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> msel_legal(mach_sel));

    // R11: no request, no result on the next cycle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> (!hit_valid && !miss && (cs_sel == '0)));

    // R5 and R6: every request yields exactly one of hit or miss
    assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> (hit_valid != miss));

endmodule

bind cs_bank_decoder csdec_checker #(.NUM_BANKS(NUM_BANKS)) u_csdec_checker (.*);

// File: tb/tb_cs_bank_decoder.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a bench-side register model.
module tb_cs_bank_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int HI_W = 17;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      boot_mode;
    logic            boot_large_page;
    logic            reg_we;
    logic [2:0]      reg_bank;
    logic            reg_sel;
    logic [31:0]     reg_wdata;
    logic            txn_valid;
    logic [31:15]    txn_addr_hi;
    logic [1:0]      txn_size;
    logic            txn_write;
    logic            hit_valid, miss, large_page, out_write;
    logic [NB-1:0]   cs_sel;
    logic [2:0]      mach_sel;
    logic [1:0]      port_size, out_size;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cs_bank_decoder dut (
        .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
        .boot_large_page(boot_large_page), .reg_we(reg_we),
        .reg_bank(reg_bank), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .txn_valid(txn_valid), .txn_addr_hi(txn_addr_hi),
        .txn_size(txn_size), .txn_write(txn_write),
        .hit_valid(hit_valid), .miss(miss), .cs_sel(cs_sel),
        .mach_sel(mach_sel), .port_size(port_size),
        .large_page(large_page), .out_size(out_size), .out_write(out_write)
    );

    // Bench model of the bank registers
    logic [HI_W-1:0] m_base [NB];
    logic [HI_W-1:0] m_mask [NB];
    logic [1:0]      m_ps   [NB];
    logic [2:0]      m_ms   [NB];
    logic            m_val  [NB];
    logic            m_pg   [NB];

    function automatic logic legal(input logic [2:0] c);
        return c == 3'b000 || c == 3'b001 || c == 3'b100 ||
               c == 3'b101 || c == 3'b110;
    endfunction

    function automatic logic [31:0] mk_base(input logic [HI_W-1:0] hi,
            input logic [1:0] ps, input logic [2:0] ms, input logic v);
        return {hi, 2'b00, ps, 3'b000, ms, 4'b0000, v};
    endfunction

    function automatic logic [31:0] mk_opt(input logic [HI_W-1:0] mk, input logic pg);
        return {mk, 4'b0000, pg, 10'b0};
    endfunction

    // Packed result: {hit, miss, cs, machine, width, page, write, size}
    function automatic logic [18:0] expect_vec(input logic v,
            input logic [HI_W-1:0] a, input logic [1:0] sz, input logic wr);
        int w = -1;
        if (!v) return '0;
        for (int i = NB - 1; i >= 0; i--)
            if (m_val[i] && (((a ^ m_base[i]) & m_mask[i]) == '0)) w = i;
        if (w < 0 || !legal(m_ms[w]))
            return {1'b0, 1'b1, 8'h00, 3'b000, 2'b00, 1'b0, wr, sz};
        return {1'b1, 1'b0, 8'(1 << w), m_ms[w], m_ps[w], m_pg[w], wr, sz};
    endfunction

    function automatic logic [18:0] actual_vec();
        return {hit_valid, miss, cs_sel, mach_sel, port_size, large_page,
                out_write, out_size};
    endfunction

    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] act = actual_vec();
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [2:0] b, input logic s, input logic [31:0] d);
        if (!s) begin
            m_base[b] = d[31:15]; m_ps[b] = d[12:11];
            m_ms[b] = d[7:5]; m_val[b] = d[0];
        end else begin
            m_mask[b] = d[31:15]; m_pg[b] = d[10];
        end
    endtask

    task automatic idle_inputs();
        reg_we = 0; reg_bank = 0; reg_sel = 0; reg_wdata = 0;
        txn_valid = 0; txn_addr_hi = 0; txn_size = 0; txn_write = 0;
    endtask

    // Reset with given straps, set the model, check the reset state
    task automatic boot_reset(input logic [1:0] mode, input logic lp);
        @(negedge clk);
        rst_n = 0; boot_mode = mode; boot_large_page = lp; idle_inputs();
        repeat (2) @(negedge clk);
        for (int i = 0; i < NB; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_ps[i] = '0;
            m_ms[i] = '0; m_val[i] = 0; m_pg[i] = 0;
        end
        case (mode)
            2'b00: begin m_ps[0] = 2'b01; m_val[0] = 1; end
            2'b01: begin m_ps[0] = 2'b10; m_val[0] = 1; end
            2'b10: begin m_ps[0] = 2'b01; m_ms[0] = 3'b001; m_val[0] = 1; m_pg[0] = lp; end
            default: ;
        endcase
        check("R9 reset", '0);
        rst_n = 1;
    endtask

    // One cycle of stimulus, optionally with a register write; result
    // is sampled at the following falling edge
    task automatic cycle(input string req, input logic v, input logic [HI_W-1:0] a,
            input logic [1:0] sz, input logic wr, input logic we,
            input logic [2:0] b, input logic s, input logic [31:0] d);
        logic [18:0] exp;
        txn_valid = v; txn_addr_hi = a; txn_size = sz; txn_write = wr;
        reg_we = we; reg_bank = b; reg_sel = s; reg_wdata = d;
        exp = expect_vec(v, a, sz, wr);
        @(posedge clk);
        if (we) model_write(b, s, d);
        @(negedge clk);
        check(req, exp);
        idle_inputs();
    endtask

    task automatic txn(input string req, input logic [HI_W-1:0] a,
            input logic [1:0] sz, input logic wr);
        cycle(req, 1'b1, a, sz, wr, 1'b0, 3'd0, 1'b0, 32'd0);
    endtask

    task automatic wreg(input logic [2:0] b, input logic s, input logic [31:0] d);
        cycle("R11 write-only", 1'b0, '0, 2'b00, 1'b0, 1'b1, b, s, d);
    endtask

    localparam logic [HI_W-1:0] FULL = '1;

    initial begin
        rst_n = 0; boot_mode = 0; boot_large_page = 0; idle_inputs();
        void'($urandom(32'd20240611));

        // R8 R9: byte NOR boot, bank 0 takes every address
        boot_reset(2'b00, 1'b0);
        txn("R8 nor8", 17'h1ABCD, 2'b11, 1'b0);
        txn("R9 catch-all", FULL, 2'b01, 1'b1);
        cycle("R11 idle", 1'b0, 17'h1FFFF, 2'b10, 1'b1, 1'b0, 3'd0, 1'b0, 32'd0);

        // R8: halfword NOR boot
        boot_reset(2'b01, 1'b1);
        txn("R8 nor16", 17'h00042, 2'b10, 1'b0);

        // R8: NAND boot with both page flags
        boot_reset(2'b10, 1'b1);
        txn("R8 nand large", 17'h0F00F, 2'b00, 1'b0);
        boot_reset(2'b10, 1'b0);
        txn("R8 nand small", 17'h10001, 2'b00, 1'b1);

        // R10: external boot leaves every request missing
        boot_reset(2'b11, 1'b1);
        txn("R10 external", 17'h00000, 2'b01, 1'b0);
        txn("R10 external", FULL, 2'b01, 1'b1);

        // R1 R3 R4: shrink bank 0, overlap banks 3 and 5
        boot_reset(2'b00, 1'b0);
        wreg(3'd0, 1'b1, mk_opt(FULL, 1'b0));
        wreg(3'd0, 1'b0, mk_base(17'h00000, 2'b01, 3'b000, 1'b1));
        wreg(3'd5, 1'b0, mk_base(17'h12000, 2'b10, 3'b101, 1'b1));
        wreg(3'd5, 1'b1, mk_opt(17'h1F000, 1'b1));
        txn("R3 bank5 only", 17'h12ABC, 2'b01, 1'b0);
        wreg(3'd3, 1'b0, mk_base(17'h12300, 2'b01, 3'b100, 1'b1));
        wreg(3'd3, 1'b1, mk_opt(17'h1FF00, 1'b0));
        txn("R4 lower wins", 17'h12345, 2'b10, 1'b1);
        txn("R3 masked bits", 17'h12E45, 2'b10, 1'b0);

        // R7: reserved code on the winner shadows bank 5
        wreg(3'd3, 1'b0, mk_base(17'h12300, 2'b01, 3'b011, 1'b1));
        txn("R7 reserved", 17'h12301, 2'b00, 1'b0);
        txn("R7 unaffected", 17'h12401, 2'b00, 1'b0);

        // R2: same-cycle write uses old values, next cycle uses new
        cycle("R2 old value", 1'b1, 17'h05000, 2'b01, 1'b0, 1'b1, 3'd6, 1'b0,
              mk_base(17'h05000, 2'b10, 3'b110, 1'b1));
        txn("R2 new value", 17'h05000, 2'b01, 1'b0);

        // R1 R3 R4 R5 R6 R7: seeded random traffic
        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 3) begin
                logic [2:0] b = 3'($urandom_range(0, 7));
                if ($urandom_range(0, 1) == 0)
                    wreg(b, 1'b0, mk_base(17'($urandom), 2'($urandom),
                         3'($urandom), $urandom_range(0, 4) != 0));
                else
                    wreg(b, 1'b1, mk_opt({4'($urandom), 13'($urandom) & 13'h0F00},
                         1'($urandom)));
            end else begin
                logic [2:0] b = 3'($urandom_range(0, 7));
                logic [HI_W-1:0] a = 17'($urandom);
                if (r < 8) a = m_base[b] ^ (17'($urandom) & ~m_mask[b]);
                cycle("R5 random", $urandom_range(0, 7) != 0, a, 2'($urandom),
                      1'($urandom), 1'b0, 3'd0, 1'b0, 32'd0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule